// File: doc/BRIEF.md
# Integer Multiply Execution Unit

This unit executes the four integer multiply operations of the RISC-V base multiply extension. Each clock it decodes a 32-bit instruction word and, if the word is a multiply, forms the full double-width product of two operand values. It widens each operand by sign or zero extension as the selected operation requires, then registers the requested half of the product as the result. A separate request line marks a compressed multiply. For that request the instruction word is ignored and the operation is always the signed×signed low product. The caller supplies the destination register's value on the first operand input, because that register is both a source and the destination.

Two enable inputs stand for the full multiply/divide extension and the multiply-only extension. If a multiply arrives while neither enable is set, the unit flags it as illegal and keeps its previous result. Outputs are registered and appear one clock after the inputs.

Top module: `mul_exec_unit`

## Requirements
- R1: A word is a multiply, and `hit_o` is 1 in the next cycle, only when bits [6:0] are 0110011, bits [31:25] are 0000001 and bit 14 (funct3 bit 2) is 0. Any other word, including funct3 values 100 to 111 under that opcode and funct7, gives `hit_o` = 0 and leaves `result_o` unchanged.
- R2: funct3 000 (bits [14:12]) gives the low XLEN bits of signed(rs1) × signed(rs2).
- R3: funct3 001 gives the high XLEN bits of signed(rs1) × signed(rs2).
- R4: funct3 010 gives the high XLEN bits of signed(rs1) × unsigned(rs2).
- R5: funct3 011 gives the high XLEN bits of unsigned(rs1) × unsigned(rs2).
- R6: If a multiply is decoded while both `en_muldiv_i` and `en_mulonly_i` are 0, `illegal_o` is 1 in the next cycle and `result_o` keeps its value. If either enable is 1, `illegal_o` is 0 and the result is written.
- R7: While `cmul_i` is 1, the unit acts as a funct3 000 multiply of `rs1_val_i` (the destination's value) and `rs2_val_i`, whatever the instruction word holds.
- R8: While `rst_n` is 0, `hit_o`, `illegal_o` and `result_o` are 0.
- R9: The product is formed at 2×XLEN bits from operands widened to XLEN+1 bits. The high half is product bits [2·XLEN−1:XLEN] and the low half is bits [XLEN−1:0]. XLEN is a parameter, 32 or 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word to decode |
| cmul_i | input | 1 | Compressed multiply request |
| en_muldiv_i | input | 1 | Full multiply/divide extension enabled |
| en_mulonly_i | input | 1 | Multiply-only extension enabled |
| rs1_val_i | input | XLEN | First source operand value |
| rs2_val_i | input | XLEN | Second source operand value |
| hit_o | output | 1 | Previous cycle decoded as a multiply |
| illegal_o | output | 1 | Previous multiply arrived with no extension enabled |
| result_o | output | XLEN | Last written multiply result |

## Verification
On every cycle the assertions check these rules:
- an illegal flag only comes with a hit, and the result holds while the flag is up;
- the result holds whenever there was no hit;
- a word with funct3 bit 2 set never hits;
- a compressed request always decodes to the signed low operation;
- any low-half result matches a plain XLEN-wide product.

Whether each high half is exactly right for its signedness cannot be shown by these properties. The bench shows it by comparing every operation against its own reference product, using the most negative value, all ones, zero and one as operands.

// File: rtl/mul_pkg.sv
package mul_pkg;

  localparam logic [6:0] OPC_REG_REG = 7'b0110011;
  localparam logic [6:0] F7_MULDIV   = 7'b0000001;

  typedef struct packed {
    logic high;
    logic sgn_a;
    logic sgn_b;
  } mul_op_t;

  localparam mul_op_t OP_LOW_SS = '{high: 1'b0, sgn_a: 1'b1, sgn_b: 1'b1};

  // funct3[1:0] picks the variant once funct3[2] is known to be zero
  function automatic mul_op_t op_from_funct3(input logic [1:0] f);
    mul_op_t o;
    case (f)
      2'b00:   o = OP_LOW_SS;
      2'b01:   o = '{high: 1'b1, sgn_a: 1'b1, sgn_b: 1'b1};
      2'b10:   o = '{high: 1'b1, sgn_a: 1'b1, sgn_b: 1'b0};
      default: o = '{high: 1'b1, sgn_a: 1'b0, sgn_b: 1'b0};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/mul_decode.sv
module mul_decode
  import mul_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic        cmul_i,
  output logic        is_mul_o,
  output mul_op_t     op_o
);

  logic [6:0] opcode_f;
  logic [6:0] funct7_f;
  logic [2:0] funct3_f;
  logic       opcode_match;
  logic       funct7_match;
  logic       funct3_mul;
  logic       unused_reg_fields;

  assign opcode_f = instr_i[6:0];
  assign funct3_f = instr_i[14:12];
  assign funct7_f = instr_i[31:25];
  assign unused_reg_fields = ^{instr_i[24:15], instr_i[11:7]};

  assign opcode_match = (opcode_f == OPC_REG_REG);
  assign funct7_match = (funct7_f == F7_MULDIV);
  assign funct3_mul   = ~funct3_f[2];

  always_comb begin
    if (cmul_i) begin
      is_mul_o = 1'b1;
      op_o     = OP_LOW_SS;
    end else begin
      is_mul_o = opcode_match & funct7_match & funct3_mul;
      op_o     = op_from_funct3(funct3_f[1:0]);
    end
  end

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  mul_op_t         op_i,
  output logic [XLEN-1:0] res_o
);

  localparam int EW = XLEN + 1;
  localparam int PW = 2 * XLEN;
  localparam int FW = 2 * EW;

  function automatic logic [EW-1:0] widen(input logic [XLEN-1:0] v, input logic s);
    return {s & v[XLEN-1], v};
  endfunction

  function automatic logic [XLEN-1:0] pick_half(input logic [PW-1:0] p, input logic hi);
    return hi ? p[PW-1:XLEN] : p[XLEN-1:0];
  endfunction

  logic [EW-1:0]        ext_a;
  logic [EW-1:0]        ext_b;
  logic signed [FW-1:0] prod_full;
  logic [PW-1:0]        prod;
  logic [FW-1:PW]       unused_prod_top;
  logic [XLEN-1:0]      low_check;

  assign ext_a     = widen(a_i, op_i.sgn_a);
  assign ext_b     = widen(b_i, op_i.sgn_b);
  assign prod_full = FW'($signed(ext_a)) * FW'($signed(ext_b));
  assign prod      = prod_full[PW-1:0];
  assign unused_prod_top = prod_full[FW-1:PW];
  assign res_o     = pick_half(prod, op_i.high);

  // low half does not depend on operand signedness
  assign low_check = a_i * b_i;

  p_low_half_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_i.high |-> (res_o == low_check));

  p_high_zero_operand_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i.high && (a_i == '0 || b_i == '0)) |-> (res_o == '0));

  p_high_uu_by_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i.high && !op_i.sgn_a && !op_i.sgn_b && b_i == XLEN'(1)) |-> (res_o == '0));

endmodule

// File: rtl/mul_exec_unit.sv
module mul_exec_unit
  import mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     instr_i,
  input  logic            cmul_i,
  input  logic            en_muldiv_i,
  input  logic            en_mulonly_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic            hit_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] result_o
);

  logic            dec_hit;
  mul_op_t         dec_op;
  logic [XLEN-1:0] dp_res;
  logic            ext_enabled;
  logic            do_write;
  logic            hit_q;
  logic            illegal_q;
  logic [XLEN-1:0] res_q;

  generate
    if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      initial $display("mul_exec_unit: XLEN must be 32 or 64");
    end
  endgenerate

  mul_decode u_decode (
    .instr_i  (instr_i),
    .cmul_i   (cmul_i),
    .is_mul_o (dec_hit),
    .op_o     (dec_op)
  );

  mul_datapath #(.XLEN(XLEN)) u_datapath (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (rs1_val_i),
    .b_i   (rs2_val_i),
    .op_i  (dec_op),
    .res_o (dp_res)
  );

  assign ext_enabled = en_muldiv_i | en_mulonly_i;
  assign do_write    = dec_hit & ext_enabled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q     <= 1'b0;
      illegal_q <= 1'b0;
      res_q     <= '0;
    end else begin
      hit_q     <= dec_hit;
      illegal_q <= dec_hit & ~ext_enabled;
      if (do_write) res_q <= dp_res;
    end
  end

  assign hit_o     = hit_q;
  assign illegal_o = illegal_q;
  assign result_o  = res_q;

  p_illegal_implies_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> hit_o);

  p_illegal_holds_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(result_o));

  p_nohit_holds_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> $stable(result_o));

  p_upper_funct3_rejected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmul_i && instr_i[14]) |=> !hit_o);

  p_cmul_low_signed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmul_i |-> (dec_hit && !dec_op.high && dec_op.sgn_a && dec_op.sgn_b));

endmodule

// File: tb/mul_exec_unit_tb_top.sv
module mul_exec_unit_tb_top;

  localparam int XLEN = 32;
  localparam int NOPS = 6;
  localparam logic [XLEN-1:0] OPS [0:NOPS-1] = '{
    32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000,
    32'h0000_0001, 32'h7FFF_FFFF, 32'h1234_5678
  };
  // directed vectors: funct3, rs1, rs2, expected result
  localparam int NVEC = 4;
  localparam logic [2:0]      VF3 [0:NVEC-1] = '{3'b000, 3'b001, 3'b010, 3'b011};
  localparam logic [XLEN-1:0] VA  [0:NVEC-1] = '{32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [XLEN-1:0] VB  [0:NVEC-1] = '{32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [XLEN-1:0] VE  [0:NVEC-1] = '{32'h8000_0000, 32'h4000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFE};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     instr = 32'h0;
  logic            cmul = 1'b0;
  logic            en_md = 1'b1;
  logic            en_mo = 1'b0;
  logic [XLEN-1:0] a = '0;
  logic [XLEN-1:0] b = '0;
  logic            hit;
  logic            illegal;
  logic [XLEN-1:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mul_exec_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .cmul_i(cmul),
    .en_muldiv_i(en_md), .en_mulonly_i(en_mo),
    .rs1_val_i(a), .rs2_val_i(b),
    .hit_o(hit), .illegal_o(illegal), .result_o(result)
  );

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [2:0] f3, input logic [6:0] opc);
    return {f7, 5'd7, 5'd5, f3, 5'd9, opc};
  endfunction

  function automatic logic [XLEN-1:0] ref_mul(input logic [2:0] f3, input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    logic [63:0] ex, ey, p;
    logic sx, sy;
    sx = (f3 != 3'b011);
    sy = (f3 == 3'b000) || (f3 == 3'b001);
    ex = sx ? {{32{x[31]}}, x} : {32'h0, x};
    ey = sy ? {{32{y[31]}}, y} : {32'h0, y};
    p  = ex * ey;
    return (f3 == 3'b000) ? p[31:0] : p[63:32];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] w, input logic c, input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    instr = w; cmul = c; a = x; b = y;
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] held;
    step(enc(7'h01, 3'b001, 7'h33), 1'b0, 32'h8000_0000, 32'h8000_0000);
    step(enc(7'h01, 3'b001, 7'h33), 1'b0, 32'h8000_0000, 32'h8000_0000);
    chk("R8 reset hit", 64'(hit), 64'd0);
    chk("R8 reset illegal", 64'(illegal), 64'd0);
    chk("R8 reset result", 64'(result), 64'd0);
    rst_n = 1'b1;

    // directed table with hand-computed results (R2 R3 R4 R5)
    for (int i = 0; i < NVEC; i++) begin
      step(enc(7'h01, VF3[i], 7'h33), 1'b0, VA[i], VB[i]);
      chk($sformatf("R%0d table vec %0d", i + 2, i), 64'(result), 64'(VE[i]));
      chk("R1 hit on table vec", 64'(hit), 64'd1);
    end

    // every variant over every pair of corner operands (R2 R3 R4 R5 R9)
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < NOPS; i++) begin
        for (int j = 0; j < NOPS; j++) begin
          step(enc(7'h01, 3'(f), 7'h33), 1'b0, OPS[i], OPS[j]);
          chk($sformatf("R%0d R9 f3=%0d a=%h b=%h", f + 2, f, OPS[i], OPS[j]),
              64'(result), 64'(ref_mul(3'(f), OPS[i], OPS[j])));
        end
      end
    end

    // R6: only the multiply-only enable set still executes
    en_md = 1'b0; en_mo = 1'b1;
    step(enc(7'h01, 3'b011, 7'h33), 1'b0, 32'hFFFF_FFFF, 32'h0000_0002);
    chk("R6 mulonly result", 64'(result), 64'h1);
    chk("R6 mulonly not illegal", 64'(illegal), 64'd0);

    // R6: neither enable -> illegal, result held
    held = result;
    en_mo = 1'b0;
    step(enc(7'h01, 3'b000, 7'h33), 1'b0, 32'h0000_0003, 32'h0000_0005);
    chk("R6 illegal flag", 64'(illegal), 64'd1);
    chk("R6 illegal hit", 64'(hit), 64'd1);
    chk("R6 illegal holds result", 64'(result), 64'(held));
    en_md = 1'b1;

    // R1: funct3 100..111 and wrong fields do not hit, result held
    step(enc(7'h01, 3'b000, 7'h33), 1'b0, 32'h0000_0006, 32'h0000_0007);
    held = result;
    chk("R2 setup result", 64'(held), 64'd42);
    for (int f = 4; f < 8; f++) begin
      step(enc(7'h01, 3'(f), 7'h33), 1'b0, 32'h0000_0009, 32'h0000_0009);
      chk($sformatf("R1 f3=%0d no hit", f), 64'(hit), 64'd0);
      chk($sformatf("R1 f3=%0d result held", f), 64'(result), 64'(held));
    end
    step(enc(7'h00, 3'b000, 7'h33), 1'b0, 32'h0000_0009, 32'h0000_0009);
    chk("R1 funct7 zero no hit", 64'(hit), 64'd0);
    chk("R1 funct7 zero held", 64'(result), 64'(held));
    step(enc(7'h01, 3'b000, 7'h3B), 1'b0, 32'h0000_0009, 32'h0000_0009);
    chk("R1 other opcode no hit", 64'(hit), 64'd0);
    chk("R1 other opcode held", 64'(result), 64'(held));

    // R7: compressed request ignores the instruction word
    step(enc(7'h01, 3'b011, 7'h33), 1'b1, 32'hFFFF_FFFF, 32'h0000_0003);
    chk("R7 cmul low signed", 64'(result), 64'hFFFF_FFFD);
    chk("R7 cmul hit", 64'(hit), 64'd1);
    step(32'h0000_0000, 1'b1, 32'h8000_0000, 32'h8000_0000);
    chk("R7 cmul with zero word", 64'(result), 64'h0);
    chk("R7 cmul zero word hit", 64'(hit), 64'd1);

    // R8: reset mid-run clears outputs
    step(enc(7'h01, 3'b000, 7'h33), 1'b0, 32'h0000_0002, 32'h0000_0002);
    rst_n = 1'b0;
    step(enc(7'h01, 3'b000, 7'h33), 1'b0, 32'h0000_0002, 32'h0000_0002);
    chk("R8 reset result", 64'(result), 64'd0);
    chk("R8 reset hit", 64'(hit), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule